// File: doc/BRIEF.md
# Latency-programmable slave memory responder

This block is a small word-organised memory on the slave side of a simple single-select register bus. A master raises a select line together with a direction flag, a byte address, write data and byte enables, and holds all of them steady until it sees an acknowledge. The responder captures the request, waits a number of cycles set by a parameter (one for reads, one for writes), then completes it with a one-cycle acknowledge on the matching line.

Requests it cannot serve exactly are refused rather than approximated. An address that is not on a word boundary, or a write whose byte enables do not cover the whole word, still gets its acknowledge, but with the error flag raised and the memory left as it was. It is meant as a latency-accurate stand-in for a slave peripheral when master logic is being brought up.

Top module: `busmem_responder`

## Requirements
- R1: While reset is asserted, both acknowledges, the error flag and the read data are 0, and every memory word is cleared to 0.
- R2: In idle, a select sampled high on a clock edge captures the request; direction flag 1 means read and 0 means write.
- R3: When a read is captured at edge k, the read acknowledge is high during the cycle after edge k+1+RD_LAT and in no other cycle of that request.
- R4: When a write is captured at edge k, the write acknowledge is high during the cycle after edge k+1+WR_LAT and in no other cycle of that request.
- R5: Each acknowledge lasts exactly one cycle, the two acknowledges are never high together, and error is 0 on a request that is served.
- R6: In the read acknowledge cycle of a served read, the read data equals the stored word whose index is the byte address shifted right by log2(DATA_WIDTH/8); in every other cycle the read data is 0.
- R7: A served write replaces the word at index address / (DATA_WIDTH/8) with the captured write data, visible to the next read.
- R8: A request whose address has any of its log2(DATA_WIDTH/8) lowest bits set completes with its matching acknowledge and error high, returns read data 0, and changes no memory word.
- R9: A write whose byte enables are not all ones completes with the write acknowledge and error high and changes no memory word.
- R10: While idle with select low, both acknowledges and error stay 0.
- R11: Select, direction, address, and for writes the byte enables and write data, must hold their captured values while a request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_sel | input | 1 | Request select from the master |
| req_rd | input | 1 | Direction: 1 read, 0 write |
| req_addr | input | ADDR_WIDTH | Byte address |
| req_wdata | input | DATA_WIDTH | Write data |
| req_ben | input | DATA_WIDTH/8 | Byte enables for a write |
| rsp_rdata | output | DATA_WIDTH | Read data, valid with the read acknowledge |
| rsp_rack | output | 1 | One-cycle read acknowledge |
| rsp_wack | output | 1 | One-cycle write acknowledge |
| rsp_err | output | 1 | Error, valid with either acknowledge |

## Verification
Reads and writes are issued to the first word, a middle word and the last word with distinct data patterns, so a wrong word index or a dropped write shows up as a stale or zero value on read-back. The bench is built with a non-zero read latency and a zero write latency, so counting cycles to each acknowledge separates the two latency paths and catches an off-by-one at the zero boundary. Misaligned reads, misaligned writes and writes with partial byte enables are each followed by a read of the affected word, telling a correctly refused request apart from one that flagged an error yet still modified memory. A behavioural model compared every cycle also catches stray acknowledges and non-zero read data outside the acknowledge cycle.

// File: rtl/busmem_pkg.sv
package busmem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RWAIT = 2'd1,
    ST_WWAIT = 2'd2
  } bm_state_t;

endpackage

// File: rtl/busmem_lat_counter.sv
module busmem_lat_counter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/busmem_store.sv
module busmem_store #(
  parameter int DW    = 32,
  parameter int IW    = 4,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[idx] <= wdata;
    end
  end

  assign rdata = words[idx];

endmodule

// File: rtl/busmem_responder.sv
module busmem_responder #(
  parameter int ADDR_WIDTH = 6,
  parameter int DATA_WIDTH = 32,
  parameter int RD_LAT     = 2,
  parameter int WR_LAT     = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_sel,
  input  logic                    req_rd,
  input  logic [ADDR_WIDTH-1:0]   req_addr,
  input  logic [DATA_WIDTH-1:0]   req_wdata,
  input  logic [DATA_WIDTH/8-1:0] req_ben,
  output logic [DATA_WIDTH-1:0]   rsp_rdata,
  output logic                    rsp_rack,
  output logic                    rsp_wack,
  output logic                    rsp_err
);
  import busmem_pkg::*;

  // DATA_WIDTH must be at least 16 so that an in-word byte offset exists.
  localparam int BYTES   = DATA_WIDTH / 8;
  localparam int OFS_W   = $clog2(BYTES);
  localparam int IW      = ADDR_WIDTH - OFS_W;
  localparam int LAT_MAX = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CW      = $clog2(LAT_MAX + 2);

  function automatic logic addr_aligned(input logic [ADDR_WIDTH-1:0] a);
    return a[OFS_W-1:0] == '0;
  endfunction

  function automatic logic [IW-1:0] word_index(input logic [ADDR_WIDTH-1:0] a);
    return a[ADDR_WIDTH-1:OFS_W];
  endfunction

  function automatic logic whole_word(input logic [BYTES-1:0] be);
    return &be;
  endfunction

  bm_state_t             state;
  logic                  cap_rd;
  logic [ADDR_WIDTH-1:0] cap_addr;
  logic [DATA_WIDTH-1:0] cap_wdata;
  logic [BYTES-1:0]      cap_ben;
  logic [CW-1:0]         wait_cnt;
  logic [DATA_WIDTH-1:0] store_q;

  // named events for the checker
  logic idle_w, rd_done_w, wr_done_w, done_w, refuse_w, mem_we_w;

  assign idle_w    = (state == ST_IDLE);
  assign rd_done_w = (state == ST_RWAIT) && (wait_cnt == CW'(RD_LAT));
  assign wr_done_w = (state == ST_WWAIT) && (wait_cnt == CW'(WR_LAT));
  assign done_w    = rd_done_w || wr_done_w;
  assign refuse_w  = !addr_aligned(cap_addr) || (!cap_rd && !whole_word(cap_ben));
  assign mem_we_w  = wr_done_w && !refuse_w;

  busmem_lat_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (idle_w),
    .cnt   (wait_cnt)
  );

  busmem_store #(.DW(DATA_WIDTH), .IW(IW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we_w),
    .idx   (word_index(cap_addr)),
    .wdata (cap_wdata),
    .rdata (store_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_rd    <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
      cap_ben   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_sel) begin
            cap_rd   <= req_rd;
            cap_addr <= req_addr;
            if (!req_rd) begin
              cap_wdata <= req_wdata;
              cap_ben   <= req_ben;
            end
            state <= req_rd ? ST_RWAIT : ST_WWAIT;
          end
        end
        ST_RWAIT, ST_WWAIT: begin
          if (done_w) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rack  <= 1'b0;
      rsp_wack  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_rack  <= rd_done_w;
      rsp_wack  <= wr_done_w;
      rsp_err   <= done_w && refuse_w;
      rsp_rdata <= (rd_done_w && !refuse_w) ? store_q : '0;
    end
  end

endmodule

// File: rtl/busmem_responder_chk.sv
module busmem_responder_chk #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_sel,
  input logic          req_rd,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [BW-1:0] req_ben,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_rack,
  input logic          rsp_wack,
  input logic          rsp_err,
  input logic          idle,
  input logic          cap_rd,
  input logic [AW-1:0] cap_addr,
  input logic [DW-1:0] cap_wdata,
  input logic [BW-1:0] cap_ben
);

  AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_rack && rsp_wack)); // R5
  AST_RACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rack |=> !rsp_rack); // R5
  AST_WACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wack |=> !rsp_wack); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !req_sel) |=> (!rsp_rack && !rsp_wack && !rsp_err)); // R10
  AST_ERR_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rack || rsp_wack)); // R8
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_rack |-> (rsp_rdata == '0)); // R6
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rack && rsp_err) |-> (rsp_rdata == '0)); // R8
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (req_sel && req_rd == cap_rd && req_addr == cap_addr)); // R11
  AST_HOLD_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !cap_rd) |-> (req_wdata == cap_wdata && req_ben == cap_ben)); // R11

endmodule

bind busmem_responder busmem_responder_chk #(
  .AW(ADDR_WIDTH), .DW(DATA_WIDTH), .BW(DATA_WIDTH/8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_rd(req_rd),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_ben(req_ben),
  .rsp_rdata(rsp_rdata), .rsp_rack(rsp_rack), .rsp_wack(rsp_wack),
  .rsp_err(rsp_err), .idle(idle_w), .cap_rd(cap_rd), .cap_addr(cap_addr),
  .cap_wdata(cap_wdata), .cap_ben(cap_ben)
);

// File: tb/sim_busmem_responder.sv
module sim_busmem_responder;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int RL = 3;
  localparam int WL = 0;
  localparam int NWORDS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_sel = 1'b0;
  logic          req_rd = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_ben = '0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_rack, rsp_wack, rsp_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  busmem_responder #(.ADDR_WIDTH(AW), .DATA_WIDTH(DW), .RD_LAT(RL), .WR_LAT(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ben(req_ben),
    .rsp_rdata(rsp_rdata), .rsp_rack(rsp_rack), .rsp_wack(rsp_wack), .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] ref_mem [NWORDS];
  int  m_left = 0;
  bit  m_busy = 0;
  bit  m_rd;
  int  m_addr;
  logic [DW-1:0] m_wd;
  logic [BW-1:0] m_be;
  logic [DW-1:0] e_rdata = '0;
  logic e_rack = 0, e_wack = 0, e_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) ref_mem[i] = '0;
      m_busy = 0;
      e_rack <= 0; e_wack <= 0; e_err <= 0; e_rdata <= '0;
    end else begin
      e_rack <= 0; e_wack <= 0; e_err <= 0; e_rdata <= '0;
      if (!m_busy) begin
        if (req_sel) begin
          m_busy = 1; m_rd = req_rd; m_addr = int'(req_addr);
          m_wd = req_wdata; m_be = req_ben;
          m_left = req_rd ? RL : WL;
        end
      end else if (m_left > 0) begin
        m_left--;
      end else begin
        bit bad;
        bad = (m_addr % BW != 0) || (!m_rd && m_be != {BW{1'b1}});
        m_busy = 0;
        e_err <= bad;
        if (m_rd) begin
          e_rack <= 1;
          if (!bad) e_rdata <= ref_mem[m_addr / BW];
        end else begin
          e_wack <= 1;
          if (!bad) ref_mem[m_addr / BW] = m_wd;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished)
      check({rsp_rack, rsp_wack, rsp_err, rsp_rdata} === {e_rack, e_wack, e_err, e_rdata},
            "per-cycle model R5,R6,R8,R10",
            64'({rsp_rack, rsp_wack, rsp_err, rsp_rdata}),
            64'({e_rack, e_wack, e_err, e_rdata}));
  end

  // one transaction; inputs held steady until the acknowledge (R11)
  task automatic xfer(input bit rd, input int addr, input logic [DW-1:0] wd,
                      input logic [BW-1:0] be, output int lat,
                      output logic [DW-1:0] rdata, output logic err, output logic other);
    @(negedge clk);
    req_sel = 1; req_rd = rd; req_addr = AW'(addr); req_wdata = wd; req_ben = be;
    lat = 0; other = 0;
    do begin
      @(negedge clk);
      lat++;
      if (rd ? rsp_wack : rsp_rack) other = 1;
    end while (!(rd ? rsp_rack : rsp_wack) && lat < 40);
    rdata = rsp_rdata; err = rsp_err;
    req_sel = 0; req_wdata = '0; req_ben = '0;
    @(negedge clk);
    if (rsp_rack || rsp_wack) other = 1;
  endtask

  task automatic do_read(input int addr, input logic [DW-1:0] exp, input bit exp_err, input string tag);
    int lat; logic [DW-1:0] d; logic e, o;
    xfer(1, addr, '0, '0, lat, d, e, o);
    check(lat == RL + 2, {tag, " R3 read latency"}, 64'(lat), 64'(RL + 2));
    check(d === exp, {tag, " R6 read data"}, 64'(d), 64'(exp));
    check(e === exp_err, {tag, " R5 R8 error flag"}, 64'(e), 64'(exp_err));
    check(!o, {tag, " R5 pulse/other ack"}, 64'(o), 64'(0));
  endtask

  task automatic do_write(input int addr, input logic [DW-1:0] wd, input logic [BW-1:0] be,
                          input bit exp_err, input string tag);
    int lat; logic [DW-1:0] d; logic e, o;
    xfer(0, addr, wd, be, lat, d, e, o);
    check(lat == WL + 2, {tag, " R4 write latency"}, 64'(lat), 64'(WL + 2));
    check(e === exp_err, {tag, " R9 R8 error flag"}, 64'(e), 64'(exp_err));
    check(!o, {tag, " R5 pulse/other ack"}, 64'(o), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({rsp_rack, rsp_wack, rsp_err, rsp_rdata} === '0, "R1 reset outputs",
          64'({rsp_rack, rsp_wack, rsp_err, rsp_rdata}), 64'(0));
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!rsp_rack && !rsp_wack && !rsp_err, "R10 idle quiet",
          64'({rsp_rack, rsp_wack, rsp_err}), 64'(0));
    do_read(0, '0, 0, "R1 cleared word");
    do_write(4, 32'hA5A5_5A5A, 4'hF, 0, "R2 R7 write w1");
    do_read(4, 32'hA5A5_5A5A, 0, "R2 R7 readback w1");
    do_write(0, 32'h1234_5678, 4'hF, 0, "R7 write w0");
    do_write(60, 32'hDEAD_BEEF, 4'hF, 0, "R7 write last");
    do_read(60, 32'hDEAD_BEEF, 0, "R6 last word");
    do_read(0, 32'h1234_5678, 0, "R6 first word");
    do_read(5, '0, 1, "R8 misaligned read");
    do_write(6, 32'hFFFF_FFFF, 4'hF, 1, "R8 misaligned write");
    do_read(4, 32'hA5A5_5A5A, 0, "R8 word unchanged");
    do_write(4, 32'h0000_0000, 4'h7, 1, "R9 partial enables");
    do_read(4, 32'hA5A5_5A5A, 0, "R9 word unchanged");
    do_write(4, 32'h0BAD_F00D, 4'h0, 1, "R9 no enables");
    do_read(4, 32'hA5A5_5A5A, 0, "R9 word still unchanged");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R3 R4 actual=%h expected=%h", 64'(0), 64'(1));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule